// File: doc/BRIEF.md
# Serial Display Data Register

This block collects segment data one bit at a time and holds it for a segment driver stage. Each rising edge of a serial shift clock moves a bit from the serial data input into a shift register that is two halves long, each half holding one bit per segment. A level-controlled load input copies the shift register into an output holding register. The output register drives the segment drivers, split into an A half and a B half.

The shift clock is a slow input, sampled and edge-detected in the system clock domain. The load path is a register that copies the shift register on every system clock edge while load is high, so it behaves as a transparent latch that trails by one cycle. Two cascade outputs are provided for chaining several devices. One comes from the last stage of the first half, for single-plane chains. The other comes from the final stage, for two-plane chains. The host sends the highest segment first, so the last bit shifted lands on segment 1 of half A.

Top module: `serial_disp_reg`

## Requirements
- R1: A rising edge on `shift_clk` (low on the previous system clock edge, high on this one) shifts the register by exactly one stage and puts `ser_din` in stage 1. With no rising edge the register does not change, and holding `shift_clk` high causes only one shift.
- R2: `tap_mid` always equals stage SEGS of the shift register, which is the bit shifted in SEGS shifts earlier.
- R3: `tap_end` always equals stage 2*SEGS, which is the bit shifted in 2*SEGS shifts earlier.
- R4: On each system clock edge where `load` is high, the output register takes the shift register contents present before that edge. The outputs therefore follow the shift register with a one-cycle lag while `load` stays high.
- R5: While `load` is low, `seg_a` and `seg_b` keep their values regardless of shifting.
- R6: After 2*SEGS shifts and a load, the last bit sent appears on `seg_a[0]` and the first bit sent appears on `seg_b[SEGS-1]`.
- R7: Stage n (1 to SEGS) drives `seg_a[n-1]`. Stage SEGS+n drives `seg_b[n-1]`. A 1 means the segment is on and a 0 means it is off.
- R8: A synchronous active-high `rst` clears the shift register, the output register and both taps to 0 at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ser_din | input | 1 | Serial segment data |
| shift_clk | input | 1 | Serial shift clock, sampled by clk |
| load | input | 1 | Level-sensitive transfer enable |
| seg_a | output | SEGS | Latched half A, bit n-1 is segment n |
| seg_b | output | SEGS | Latched half B, bit n-1 is segment n |
| tap_mid | output | 1 | Cascade output from stage SEGS |
| tap_end | output | 1 | Cascade output from stage 2*SEGS |

## Verification
The bench builds the block with SEGS=8, giving a 16-stage register. With this size, a walking one and a walking zero can each visit every stage, tap and output bit. A run of arithmetic patterns then crosses the half boundary many times. The small depth also lets each tap be compared after every single shift. It also makes held-load, transparent-load, long shift-clock-high and mid-stream reset cases short enough to run in sequence.

// File: rtl/dispreg_pkg.sv
package dispreg_pkg;
    localparam int DEF_SEGS = 80;

    typedef struct packed {
        logic mid;
        logic last;
    } cascade_t;

    function automatic int stages_for(input int segs);
        return 2 * segs;
    endfunction
endpackage

// File: rtl/dispreg_edge.sv
module dispreg_edge (
    input  logic clk,
    input  logic rst,
    input  logic level_in,
    output logic rise
);
    logic level_q;

    always_ff @(posedge clk) begin
        if (rst) level_q <= 1'b0;
        else     level_q <= level_in;
    end

    assign rise = level_in & ~level_q;
endmodule

// File: rtl/dispreg_shifter.sv
module dispreg_shifter
    import dispreg_pkg::*;
#(
    parameter int SEGS = DEF_SEGS
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     step,
    input  logic                     din,
    output logic [2*SEGS-1:0]        stages,
    output cascade_t                 taps
);
    localparam int NSTG = stages_for(SEGS);

    for (genvar k = 0; k < NSTG; k++) begin : g_stage
        if (k == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (rst)       stages[k] <= 1'b0;
                else if (step) stages[k] <= din;
            end
        end else begin : g_body
            always_ff @(posedge clk) begin
                if (rst)       stages[k] <= 1'b0;
                else if (step) stages[k] <= stages[k-1];
            end
        end
    end

    assign taps.mid  = stages[SEGS-1];
    assign taps.last = stages[NSTG-1];
endmodule

// File: rtl/dispreg_hold.sv
module dispreg_hold #(
    parameter int W = 160
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         pass,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)       q <= '0;
        else if (pass) q <= d;
    end
endmodule

// File: rtl/serial_disp_reg.sv
module serial_disp_reg
    import dispreg_pkg::*;
#(
    parameter int SEGS = DEF_SEGS
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            ser_din,
    input  logic            shift_clk,
    input  logic            load,
    output logic [SEGS-1:0] seg_a,
    output logic [SEGS-1:0] seg_b,
    output logic            tap_mid,
    output logic            tap_end
);
    localparam int NSTG = stages_for(SEGS);

    logic            step;
    logic [NSTG-1:0] sr;
    logic [NSTG-1:0] held;
    cascade_t        taps;

    dispreg_edge u_edge (
        .clk      (clk),
        .rst      (rst),
        .level_in (shift_clk),
        .rise     (step)
    );

    dispreg_shifter #(.SEGS(SEGS)) u_shift (
        .clk    (clk),
        .rst    (rst),
        .step   (step),
        .din    (ser_din),
        .stages (sr),
        .taps   (taps)
    );

    dispreg_hold #(.W(NSTG)) u_hold (
        .clk  (clk),
        .rst  (rst),
        .pass (load),
        .d    (sr),
        .q    (held)
    );

    assign seg_a   = held[SEGS-1:0];
    assign seg_b   = held[NSTG-1:SEGS];
    assign tap_mid = taps.mid;
    assign tap_end = taps.last;
endmodule

// File: rtl/serial_disp_reg_chk.sv
module serial_disp_reg_chk #(
    parameter int SEGS = 80
) (
    input logic            clk,
    input logic            rst,
    input logic            ser_din,
    input logic            shift_clk,
    input logic            load,
    input logic [SEGS-1:0] seg_a,
    input logic [SEGS-1:0] seg_b,
    input logic            tap_mid,
    input logic            tap_end,
    input logic [2*SEGS-1:0] sr
);
    // R1
    shift_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && shift_clk && !$past(shift_clk)) |=>
            (sr == {$past(sr[2*SEGS-2:0]), $past(ser_din)}));
    // R1
    shift_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !(shift_clk && !$past(shift_clk))) |=> $stable(sr));
    // R2
    tap_mid_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && shift_clk && !$past(shift_clk)) |=> (tap_mid == $past(sr[SEGS-2])));
    // R3
    tap_end_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && shift_clk && !$past(shift_clk)) |=> (tap_end == $past(sr[2*SEGS-2])));
    // R4
    load_pass_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> ({seg_b, seg_a} == $past(sr)));
    // R5
    load_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !load |=> ($stable(seg_a) && $stable(seg_b)));
    // R8
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (sr == '0 && seg_a == '0 && seg_b == '0 && !tap_mid && !tap_end));
endmodule

bind serial_disp_reg serial_disp_reg_chk #(.SEGS(SEGS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ser_din   (ser_din),
    .shift_clk (shift_clk),
    .load      (load),
    .seg_a     (seg_a),
    .seg_b     (seg_b),
    .tap_mid   (tap_mid),
    .tap_end   (tap_end),
    .sr        (sr)
);

// File: tb/serial_disp_reg_tb.sv
module serial_disp_reg_tb;
    localparam int SEGS = 8;
    localparam int N    = 2 * SEGS;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ser_din = 1'b0;
    logic shift_clk = 1'b0;
    logic load = 1'b0;
    logic [SEGS-1:0] seg_a, seg_b;
    logic tap_mid, tap_end;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 1'b0;
    logic [N-1:0] m = '0;

    always #4 clk = ~clk;

    serial_disp_reg #(.SEGS(SEGS)) u_dut (
        .clk(clk), .rst(rst), .ser_din(ser_din), .shift_clk(shift_clk),
        .load(load), .seg_a(seg_a), .seg_b(seg_b),
        .tap_mid(tap_mid), .tap_end(tap_end)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000 && !done) begin
            done = 1'b1;
            fails = fails + 1;
            checks = checks + 1;
            $display("FAIL watchdog: run did not finish (actual %0d cycles, expected < 150000)", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic shift_bit(input logic b);
        @(negedge clk);
        ser_din = b;
        shift_clk = 1'b1;
        @(negedge clk);
        shift_clk = 1'b0;
        m = {m[N-2:0], b};
        // R2 R3: taps after every shift
        chk("R2", N'(tap_mid), N'(m[SEGS-1]));
        chk("R3", N'(tap_end), N'(m[N-1]));
    endtask

    task automatic send_word(input logic [N-1:0] w);
        for (int i = N - 1; i >= 0; i--) shift_bit(w[i]);
    endtask

    task automatic pulse_load;
        @(negedge clk);
        load = 1'b1;
        @(negedge clk);
        load = 1'b0;
    endtask

    initial begin
        logic [N-1:0] w;
        logic [N-1:0] held;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R8: reset state
        chk("R8", {seg_b, seg_a}, '0);
        chk("R8", N'({tap_end, tap_mid}), '0);

        // R6 R7: walking one and walking zero over every stage
        for (int j = 0; j < N; j++) begin
            w = N'(1) << j;
            send_word(w);
            pulse_load();
            chk("R7", {seg_b, seg_a}, w);
            send_word(~w);
            pulse_load();
            chk("R7", {seg_b, seg_a}, ~w);
        end

        // R6: last bit sent on seg_a[0], first on seg_b[SEGS-1]
        send_word(N'(16'h8001));
        pulse_load();
        chk("R6", N'(seg_a[0]), N'(1));
        chk("R6", N'(seg_b[SEGS-1]), N'(1));
        chk("R6", N'({seg_b[SEGS-2:0], seg_a[SEGS-1:1]}), '0);

        // R5: shifting with load low leaves outputs unchanged
        for (int p = 0; p < 64; p++) begin
            w = N'((p * 40503 + 12345) ^ (p << 7));
            held = {seg_b, seg_a};
            send_word(w);
            chk("R5", {seg_b, seg_a}, held);
            pulse_load();
            chk("R4", {seg_b, seg_a}, w);
        end

        // R1: shift_clk held high for many cycles shifts once
        w = m;
        @(negedge clk);
        ser_din = 1'b1;
        shift_clk = 1'b1;
        for (int c = 0; c < 6; c++) begin
            @(negedge clk);
            ser_din = ~ser_din;
        end
        shift_clk = 1'b0;
        m = {w[N-2:0], 1'b1};
        pulse_load();
        chk("R1", {seg_b, seg_a}, m);
        // R1: no edge, no shift
        ser_din = 1'b0;
        repeat (5) @(negedge clk);
        pulse_load();
        chk("R1", {seg_b, seg_a}, m);

        // R4: transparent load follows with one-cycle lag
        @(negedge clk);
        load = 1'b1;
        for (int i = 0; i < N + 3; i++) begin
            shift_bit(logic'((i % 3) == 0));
            @(negedge clk);
            chk("R4", {seg_b, seg_a}, m);
        end
        load = 1'b0;

        // R8: mid-stream reset
        send_word(N'(16'hA5C3));
        pulse_load();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        m = '0;
        chk("R8", {seg_b, seg_a}, '0);
        chk("R8", N'({tap_end, tap_mid}), '0);

        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule